// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block shapes what a host read returns while a non-volatile memory runs one of its internal operations. It also times those operations. A one-cycle start pulse launches either a word program or an erase. From that pulse the block holds a busy flag for a fixed, parameterised number of clock cycles. While busy, it replaces two bits of the read word with status information. Outside those bits, and whenever no operation runs, the array read data passes through unchanged.

Two status schemes run side by side, and host software may use either one.

- **Polling bit:** during a program, the polling bit shows the inverse of the same bit of the word being written. During an erase, the polling bit reads 0.
- **Toggle bit:** this bit changes value on every new read access made while busy.

A read access begins when output enable and chip enable are both low, whichever of the two falls last. Once the timer expires, both schemes give way to true data at once. The synchronous reset aborts any running operation. The word being programmed is then undefined in the array, which is outside this block.

Top module: `eosr_status_reporter`

## Requirements
- R1: After reset, busy is 0 and rdata equals array_rdata on all bits; the toggle state starts at 0.
- R2: A prog_start pulse while idle makes busy 1 from the next cycle for exactly PROG_CYCLES cycles, after which busy returns to 0.
- R3: An erase_start pulse while idle makes busy 1 from the next cycle for exactly ERASE_CYCLES cycles, after which busy returns to 0.
- R4: While a program is busy, rdata bit POLL_BIT (default 7) is the inverse of load_poll_bit as sampled with the start pulse.
- R5: While an erase is busy, rdata bit POLL_BIT reads 0.
- R6: While busy, rdata bit TGL_BIT (default 6) inverts once for each read access start. That is any clock where oe_n and ce_n are both low, but were not both low in the previous clock. The bit inverts from the following cycle. Holding the access steady causes no further change.
- R7: While idle, rdata equals array_rdata on all bits, and read accesses leave the toggle state unchanged. The next operation shows the value the toggle bit had at the end of the previous one.
- R8: Start pulses arriving while busy are ignored. They neither restart the timer, nor change the operation kind, nor relatch load_poll_bit.
- R9: rst asserted during an operation aborts it, and busy is 0 in the next cycle.
- R10: While busy, every rdata bit other than POLL_BIT and TGL_BIT equals array_rdata.
- R11: If prog_start and erase_start arrive in the same idle cycle, an erase is started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; aborts a running operation |
| prog_start | input | 1 | One-cycle pulse starting a word program |
| erase_start | input | 1 | One-cycle pulse starting an erase |
| load_poll_bit | input | 1 | Bit POLL_BIT of the word being programmed, sampled with prog_start |
| oe_n | input | 1 | Output enable, active low |
| ce_n | input | 1 | Chip enable, active low |
| array_rdata | input | DATA_W | Word read from the array |
| rdata | output | DATA_W | Read word with status bits inserted while busy |
| busy | output | 1 | High while an operation is being timed |

## Verification
A read access can start in the same cycle as either the timer's final busy cycle or a start pulse.

- **Final busy cycle:** a read starting there still inverts the toggle state, because busy is high in that cycle.
- **Start pulse:** a read starting with the pulse does not invert it, because busy is still low.

The bench hits both coincidences on purpose, and random access traffic keeps hitting them as well. A bench model counts access starts only in cycles where its own busy copy is high. It compares bit TGL_BIT after every clock. A wrong rule on either edge then shows up as a mismatch in the toggle value, which persists into the next operation.

// File: rtl/eosr_pkg.sv
package eosr_pkg;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     wr_bit;   // bit POLL_BIT of the word being written
    } op_ctx_t;

    // Value shown on the polling bit while an operation is busy
    function automatic logic poll_value(op_ctx_t ctx);
        return (ctx.kind == OP_ERASE) ? 1'b0 : ~ctx.wr_bit;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eosr_op_timer.sv
module eosr_op_timer
    import eosr_pkg::*;
#(
    parameter int unsigned PROG_CYCLES  = 20,
    parameter int unsigned ERASE_CYCLES = 60
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    prog_start,
    input  logic    erase_start,
    input  logic    load_poll_bit,
    output logic    busy,
    output op_ctx_t ctx
);
    localparam int unsigned LONGEST = max_u(PROG_CYCLES, ERASE_CYCLES);
    localparam int unsigned CNT_W   = $clog2(LONGEST + 1);
    localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES);
    localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES);

    logic [CNT_W-1:0] remain_q;
    logic             busy_q;
    op_ctx_t          ctx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            remain_q <= '0;
            ctx_q    <= '{kind: OP_PROG, wr_bit: 1'b0};
        end else if (busy_q) begin
            if (remain_q == CNT_W'(1)) begin
                busy_q <= 1'b0;
            end
            remain_q <= remain_q - CNT_W'(1);
        end else if (erase_start) begin
            busy_q   <= 1'b1;
            remain_q <= ERASE_LOAD;
            ctx_q    <= '{kind: OP_ERASE, wr_bit: 1'b0};
        end else if (prog_start) begin
            busy_q   <= 1'b1;
            remain_q <= PROG_LOAD;
            ctx_q    <= '{kind: OP_PROG, wr_bit: load_poll_bit};
        end
    end

    assign busy = busy_q;
    assign ctx  = ctx_q;

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy_q && remain_q != CNT_W'(1)) |=> busy_q); // R2
    AST_BUSY_END: assert property (@(posedge clk) disable iff (rst)
        (busy_q && remain_q == CNT_W'(1)) |=> !busy_q); // R3
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_q && (prog_start || erase_start)) |=> $stable(ctx_q)); // R8
    AST_ABORT: assert property (@(posedge clk)
        rst |=> !busy_q); // R9
    AST_ERASE_WINS: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && erase_start) |=> (busy_q && ctx_q.kind == OP_ERASE)); // R11

endmodule

// File: rtl/eosr_toggle.sv
module eosr_toggle (
    input  logic clk,
    input  logic rst,
    input  logic oe_n,
    input  logic ce_n,
    input  logic busy,
    output logic tgl
);
    logic access;
    logic access_q;
    logic access_start;
    logic tgl_q;

    assign access       = !oe_n && !ce_n;
    assign access_start = access && !access_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            access_q <= 1'b0;
            tgl_q    <= 1'b0;
        end else begin
            access_q <= access;
            if (busy && access_start) begin
                tgl_q <= ~tgl_q;
            end
        end
    end

    assign tgl = tgl_q;

    AST_TGL_FLIP: assert property (@(posedge clk) disable iff (rst)
        (busy && access_start) |=> (tgl_q != $past(tgl_q))); // R6
    AST_TGL_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
        (busy && access && access_q) |=> $stable(tgl_q)); // R6
    AST_TGL_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(tgl_q)); // R7

endmodule

// File: rtl/eosr_status_reporter.sv
module eosr_status_reporter
    import eosr_pkg::*;
#(
    parameter int unsigned DATA_W       = 16,
    parameter int unsigned POLL_BIT     = 7,
    parameter int unsigned TGL_BIT      = 6,
    parameter int unsigned PROG_CYCLES  = 20,
    parameter int unsigned ERASE_CYCLES = 60
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_start,
    input  logic              erase_start,
    input  logic              load_poll_bit,
    input  logic              oe_n,
    input  logic              ce_n,
    input  logic [DATA_W-1:0] array_rdata,
    output logic [DATA_W-1:0] rdata,
    output logic              busy
);
    logic    op_busy;
    op_ctx_t op_ctx;
    logic    tgl_bit;

    eosr_op_timer #(
        .PROG_CYCLES (PROG_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES)
    ) u_timer (
        .clk          (clk),
        .rst          (rst),
        .prog_start   (prog_start),
        .erase_start  (erase_start),
        .load_poll_bit(load_poll_bit),
        .busy         (op_busy),
        .ctx          (op_ctx)
    );

    eosr_toggle u_toggle (
        .clk (clk),
        .rst (rst),
        .oe_n(oe_n),
        .ce_n(ce_n),
        .busy(op_busy),
        .tgl (tgl_bit)
    );

    always_comb begin
        rdata = array_rdata;
        if (op_busy) begin
            rdata[POLL_BIT] = poll_value(op_ctx);
            rdata[TGL_BIT]  = tgl_bit;
        end
    end

    assign busy = op_busy;

    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
        !op_busy |-> (rdata == array_rdata)); // R7
    AST_ERASE_POLL: assert property (@(posedge clk) disable iff (rst)
        (op_busy && op_ctx.kind == OP_ERASE) |-> !rdata[POLL_BIT]); // R5
    AST_PROG_POLL: assert property (@(posedge clk) disable iff (rst)
        (op_busy && op_ctx.kind == OP_PROG) |-> (rdata[POLL_BIT] == ~op_ctx.wr_bit)); // R4

endmodule

// File: tb/eosr_status_reporter_tb.sv
module eosr_status_reporter_tb;
    localparam int DW = 16;
    localparam int PB = 7;
    localparam int TB = 6;
    localparam int PC = 20;
    localparam int EC = 60;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic prog_start = 1'b0, erase_start = 1'b0, load_poll_bit = 1'b0;
    logic oe_n = 1'b1, ce_n = 1'b1;
    logic [DW-1:0] array_rdata = '0;
    logic [DW-1:0] rdata;
    logic busy;

    always #2 clk = ~clk;

    eosr_status_reporter #(.DATA_W(DW), .POLL_BIT(PB), .TGL_BIT(TB),
        .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) u_dut (
        .clk(clk), .rst(rst), .prog_start(prog_start), .erase_start(erase_start),
        .load_poll_bit(load_poll_bit), .oe_n(oe_n), .ce_n(ce_n),
        .array_rdata(array_rdata), .rdata(rdata), .busy(busy));

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model of the requirements
    bit m_busy = 0, m_erase = 0, m_wr = 0, m_tgl = 0, m_acc_q = 0;
    int m_cnt = 0;

    function automatic logic [DW-1:0] exp_rdata();
        logic [DW-1:0] e;
        e = array_rdata;
        if (m_busy) begin
            e[PB] = m_erase ? 1'b0 : ~m_wr;
            e[TB] = m_tgl;
        end
        return e;
    endfunction

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_now(string ctx);
        logic [DW-1:0] e;
        logic [DW-1:0] m;
        e = exp_rdata();
        chk({ctx, m_busy ? (m_erase ? " R3 busy" : " R2 busy") : " R1 idle busy"},
            DW'(busy), DW'(m_busy));
        if (m_busy) begin
            chk({ctx, m_erase ? " R5 poll" : " R4 poll"}, DW'(rdata[PB]), DW'(e[PB]));
            chk({ctx, " R6 toggle"}, DW'(rdata[TB]), DW'(e[TB]));
            m = ~((DW'(1) << PB) | (DW'(1) << TB));
            chk({ctx, " R10 passthru"}, rdata & m, e & m);
        end else begin
            chk({ctx, " R7 idle data"}, rdata, e);
        end
    endtask

    function automatic void model_step();
        bit acc, stb;
        acc = !oe_n && !ce_n;
        stb = acc && !m_acc_q;
        if (rst) begin
            m_busy = 0; m_erase = 0; m_wr = 0; m_tgl = 0; m_acc_q = 0; m_cnt = 0;
        end else begin
            if (m_busy && stb) m_tgl = ~m_tgl;
            if (m_busy) begin
                if (m_cnt == 1) m_busy = 0;
                m_cnt--;
            end else if (erase_start) begin   // R11 erase has priority
                m_busy = 1; m_cnt = EC; m_erase = 1; m_wr = 0;
            end else if (prog_start) begin
                m_busy = 1; m_cnt = PC; m_erase = 0; m_wr = load_poll_bit;
            end
            m_acc_q = acc;
        end
    endfunction

    // one cycle: drive at negedge, check, advance model for next posedge
    task automatic cyc(string ctx, bit r, bit ps, bit es, bit wb, bit oe, bit ce,
                       logic [DW-1:0] ad);
        @(negedge clk);
        rst = r; prog_start = ps; erase_start = es; load_poll_bit = wb;
        oe_n = oe; ce_n = ce; array_rdata = ad;
        #1;
        check_now(ctx);
        model_step();
    endtask

    task automatic idle(string ctx, int n);
        for (int i = 0; i < n; i++) cyc(ctx, 0, 0, 0, 0, 1, 1, DW'($urandom));
    endtask

    task automatic read_pulse(string ctx);
        cyc(ctx, 0, 0, 0, 0, 0, 0, DW'($urandom));
        cyc(ctx, 0, 0, 0, 0, 1, 0, DW'($urandom));
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        // R1 reset state
        m_busy = 0;
        cyc("R1 reset", 1, 0, 0, 0, 1, 1, 16'hA5C3);
        cyc("R1 reset", 1, 0, 0, 0, 0, 0, 16'h3C5A);
        idle("R1 after reset", 2);

        // R2/R4 program with written bit 1, reads via oe toggling
        cyc("R2 start prog", 0, 1, 0, 1, 1, 0, 16'h00FF);
        for (int i = 0; i < PC / 2 + 2; i++) begin
            cyc("R4 R6 oe strobe", 0, 0, 0, 0, 0, 0, 16'hFFFF);
            cyc("R4 R6 oe strobe", 0, 0, 0, 0, 1, 0, 16'h0000);
        end
        idle("R2 done", 3);

        // R6 held access gives a single flip; ce-strobed reads
        cyc("R2 start prog0", 0, 1, 0, 0, 1, 1, 16'h1234);
        for (int i = 0; i < 5; i++) cyc("R6 held", 0, 0, 0, 0, 0, 0, 16'h1234);
        for (int i = 0; i < 6; i++) begin
            cyc("R6 ce strobe", 0, 0, 0, 0, 0, 1, 16'h5678);
            cyc("R6 ce strobe", 0, 0, 0, 0, 0, 0, 16'h9ABC);
        end
        idle("R2 tail", PC);

        // R7 reads while idle do not disturb toggle state
        for (int i = 0; i < 4; i++) read_pulse("R7 idle read");

        // R3/R5 erase with R8 ignored starts
        cyc("R3 start erase", 0, 0, 1, 0, 1, 1, 16'hFFFF);
        cyc("R8 prog while busy", 0, 1, 0, 1, 1, 1, 16'hFF7F);
        for (int i = 0; i < 10; i++) read_pulse("R5 erase read");
        cyc("R8 erase while busy", 0, 0, 1, 0, 1, 1, 16'hFFFF);
        idle("R3 tail", EC);

        // R11 simultaneous starts
        cyc("R11 both", 0, 1, 1, 1, 1, 1, 16'h0F0F);
        idle("R11 erase busy", 4);
        // R9 abort
        cyc("R9 abort", 1, 0, 0, 0, 1, 1, 16'h0F0F);
        idle("R9 after abort", 3);

        // corner: read start on final busy cycle, and on start cycle
        cyc("R6 start+read", 0, 1, 0, 1, 0, 0, 16'h4444);
        cyc("R6 start+read", 0, 0, 0, 0, 1, 1, 16'h4444);
        idle("R2 run", PC - 2);
        cyc("R6 last busy read", 0, 0, 0, 0, 0, 0, 16'h8888);
        idle("R7 after last read", 3);
        cyc("R2 next op", 0, 1, 0, 0, 1, 1, 16'h1111);
        idle("R7 toggle carried", 3);
        idle("R2 drain", PC);

        // constrained random traffic
        for (int i = 0; i < 6000; i++) begin
            int p;
            bit r, ps, es;
            p = $urandom_range(0, 999);
            r = (p < 3);
            ps = ($urandom_range(0, 99) < 4);
            es = ($urandom_range(0, 99) < 2);
            cyc("random", r, ps, es, 1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0),
                DW'($urandom));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule